// File: doc/BRIEF.md
# Output Pixel Repeater And Segmenter

This block sits at the tail of a display pipe. It collects one line of pixels from an upstream stream with valid/ready flow control and stores it in a local line store. It then plays the line back as a pixel stream in which each stored pixel is sent a programmable number of times. The line can be cut into one, two or four equal segments for a panel that is driven in several slices. Every segment after the first begins by re-sending a programmable number of pixels from the tail of the segment before it. Each segment can also end with a programmable run of filler pixels.

Every output beat carries the index of the segment it belongs to, and the last beat of a segment is flagged. While it plays a line back, the block accepts no input. The configuration inputs are taken when the first pixel of a line arrives. If the width cannot be split evenly into the requested number of segments, the block raises an error flag and sends the line as a single segment.

Top module: `pix_repeat_segmenter`

## Requirements
- R1: `inReady` is high while a line is being collected and goes low from the cycle after the last pixel of the line (pixel number `cfgWidth`) is accepted. It stays low until the final output beat of the line. Output beats other than the final one never coincide with `inReady` high.
- R2: Each output pixel is sent `cfgRepeat + 1` times on consecutive beats, with `cfgRepeat` ranging from 0 to 15. A value of 0 sends each pixel once.
- R3: `cfgSegMode` encodes the segment count as 0 = one, 1 = two, 2 = four. With S segments and seg = `cfgWidth`/S, segment s covers pixels s*seg to (s+1)*seg-1 in ascending order. Segments are sent in order 0..S-1, and each beat carries s on `outSegIdx`.
- R4: Every segment s > 0 starts `cfgOverlap` pixels early, at s*seg - `cfgOverlap`, clamped to pixel 0. `cfgOverlap` may be 0 to 8.
- R5: After the last real pixel of each segment, `cfgPad` filler beats follow. Each filler beat carries the value of that last real pixel.
- R6: `outLast` is high on exactly one beat per segment, the final beat of that segment. This is the final filler beat when `cfgPad` > 0, and otherwise the last repetition of the last pixel.
- R7: If `cfgSegMode` is 1 with an odd width, or 2 with a width not divisible by 4, or 3, then `cfgErr` is high for that line and the line is sent as one segment with index 0.
- R8: All configuration inputs are sampled with the first pixel of a line. Changes made to them later in the line have no effect on that line's output.
- R9: After reset, `outValid` is 0, `inReady` is 1 and `cfgErr` is 0 while the configuration inputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inPixel | input | PIX_W | Incoming pixel |
| inValid | input | 1 | Incoming pixel present |
| inReady | output | 1 | Block can accept a pixel |
| cfgWidth | input | clog2(MAX_W)+1 | Active pixels per line, 1..MAX_W |
| cfgSegMode | input | 2 | Segment count code |
| cfgOverlap | input | 4 | Overlap pixels per later segment |
| cfgRepeat | input | 4 | Extra repetitions per pixel |
| cfgPad | input | PAD_W | Filler beats per segment |
| outPixel | output | PIX_W | Output pixel |
| outValid | output | 1 | Output beat present |
| outSegIdx | output | 2 | Segment of the current beat |
| outLast | output | 1 | Final beat of a segment |
| cfgErr | output | 1 | Width does not split into the requested segments |

## Verification
The assertions check on every cycle that the repeat, filler and read counters stay inside their programmed limits and that the segment index stays within the segment count. They also check that collection and playback never overlap, that the segment index changes only right after a flagged last beat, and that an error line uses only segment 0. Only the bench's scenarios can show the actual sequence of output values. That sequence covers the overlap start points including the clamp, filler values equal to the last real pixel, the exact position of the last flag, and that late configuration changes are ignored. The bench compares each scenario beat by beat against a model built from the requirements.

// File: rtl/pixrep_pkg.sv
package pixrep_pkg;

  localparam logic [1:0] MODE_ONE  = 2'd0;
  localparam logic [1:0] MODE_TWO  = 2'd1;
  localparam logic [1:0] MODE_FOUR = 2'd2;

  typedef enum logic {ST_FILL, ST_EMIT} phase_t;

  typedef struct packed {
    logic       wrEn;
    logic       emitPix;
    logic       emitPad;
    logic       last;
    logic [1:0] seg;
  } pixrep_strobe_t;

endpackage

// File: rtl/pixrep_ctrl.sv
module pixrep_ctrl
  import pixrep_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int AW    = 6,
  parameter int WW    = 7,
  parameter int OVL_W = 4,
  parameter int REP_W = 4,
  parameter int PAD_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WW-1:0]    cfgWidth,
  input  logic [1:0]       cfgSegMode,
  input  logic [OVL_W-1:0] cfgOverlap,
  input  logic [REP_W-1:0] cfgRepeat,
  input  logic [PAD_W-1:0] cfgPad,
  output pixrep_strobe_t   strb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic             cfgErr
);

  phase_t             phase;
  logic [WW-1:0]      wrCnt;
  logic [WW-1:0]      widthQ;
  logic [1:0]         shiftQ;
  logic [OVL_W-1:0]   ovlQ;
  logic [REP_W-1:0]   repQ;
  logic [PAD_W-1:0]   padQ;
  logic               errQ;
  logic [1:0]         segIdx;
  logic [WW-1:0]      segBase;
  logic [WW-1:0]      rdIdx;
  logic [REP_W-1:0]   repCnt;
  logic [PAD_W-1:0]   padCnt;
  logic               inPad;

  logic               useLive;
  logic               liveErr;
  logic [1:0]         liveShift;
  logic [WW-1:0]      effWidth;
  logic [WW-1:0]      segW;
  logic [WW-1:0]      segEnd;
  logic [WW-1:0]      nextBase;
  logic [WW-1:0]      nextStart;
  logic [WW-1:0]      ovlW;
  logic [1:0]         segMax;
  logic               lastSeg;
  logic               pixDone;
  logic               atEnd;

  // configuration is live only while waiting for the first pixel of a line
  assign useLive  = (phase == ST_FILL) && (wrCnt == '0);
  assign effWidth = useLive ? cfgWidth : widthQ;

  always_comb begin
    case (cfgSegMode)
      MODE_ONE:  liveErr = 1'b0;
      MODE_TWO:  liveErr = cfgWidth[0];
      MODE_FOUR: liveErr = |cfgWidth[1:0];
      default:   liveErr = 1'b1;
    endcase
    liveShift = liveErr ? 2'd0 : cfgSegMode;
  end

  // segment geometry, division by shifting since counts are powers of two
  assign segW      = widthQ >> shiftQ;
  assign segEnd    = segBase + segW - WW'(1);
  assign nextBase  = segBase + segW;
  assign ovlW      = WW'(ovlQ);
  assign nextStart = (nextBase >= ovlW) ? (nextBase - ovlW) : '0;

  always_comb begin
    case (shiftQ)
      2'd0:    segMax = 2'd0;
      2'd1:    segMax = 2'd1;
      default: segMax = 2'd3;
    endcase
  end

  assign lastSeg = (segIdx == segMax);
  assign pixDone = (repCnt == repQ);
  assign atEnd   = (rdIdx == segEnd);

  always_comb begin
    strb.wrEn    = (phase == ST_FILL) && inValid;
    strb.emitPix = (phase == ST_EMIT) && !inPad;
    strb.emitPad = (phase == ST_EMIT) && inPad;
    strb.seg     = segIdx;
    if (phase != ST_EMIT)
      strb.last = 1'b0;
    else if (inPad)
      strb.last = (padCnt == padQ);
    else
      strb.last = atEnd && pixDone && (padQ == '0);
  end

  assign inReady = (phase == ST_FILL);
  assign wrAddr  = wrCnt[AW-1:0];
  assign rdAddr  = rdIdx[AW-1:0];
  assign cfgErr  = errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= ST_FILL;
      wrCnt   <= '0;
      widthQ  <= '0;
      shiftQ  <= '0;
      ovlQ    <= '0;
      repQ    <= '0;
      padQ    <= '0;
      errQ    <= 1'b0;
      segIdx  <= '0;
      segBase <= '0;
      rdIdx   <= '0;
      repCnt  <= '0;
      padCnt  <= '0;
      inPad   <= 1'b0;
    end else begin
      if (useLive) begin
        widthQ <= cfgWidth;
        shiftQ <= liveShift;
        ovlQ   <= cfgOverlap;
        repQ   <= cfgRepeat;
        padQ   <= cfgPad;
        errQ   <= liveErr;
      end
      case (phase)
        ST_FILL: begin
          if (strb.wrEn) begin
            if (wrCnt + WW'(1) == effWidth) begin
              phase   <= ST_EMIT;
              wrCnt   <= '0;
              segIdx  <= '0;
              segBase <= '0;
              rdIdx   <= '0;
              repCnt  <= '0;
              padCnt  <= '0;
              inPad   <= 1'b0;
            end else begin
              wrCnt <= wrCnt + WW'(1);
            end
          end
        end
        default: begin
          if (strb.last) begin
            repCnt <= '0;
            padCnt <= '0;
            inPad  <= 1'b0;
            if (lastSeg) begin
              phase <= ST_FILL;
            end else begin
              segIdx  <= segIdx + 2'd1;
              segBase <= nextBase;
              rdIdx   <= nextStart;
            end
          end else if (inPad) begin
            padCnt <= padCnt + PAD_W'(1);
          end else if (!pixDone) begin
            repCnt <= repCnt + REP_W'(1);
          end else begin
            repCnt <= '0;
            if (atEnd) begin
              inPad  <= 1'b1;
              padCnt <= PAD_W'(1);
            end else begin
              rdIdx <= rdIdx + WW'(1);
            end
          end
        end
      endcase
    end
  end

  // R2: the repeat counter never runs past the programmed count
  assert_rep_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_EMIT) |-> (repCnt <= repQ));

  // R3: the segment index stays inside the active segment count
  assert_seg_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_EMIT) |-> (segIdx <= segMax));

  // R4: playback reads only inside the stored line
  assert_read_in_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_EMIT) |-> (rdIdx < widthQ));

  // R5: filler counter stays between one and the programmed count
  assert_pad_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    inPad |-> ((padCnt != '0) && (padCnt <= padQ)));

endmodule

// File: rtl/pixrep_datapath.sv
module pixrep_datapath
  import pixrep_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int MAX_W = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  pixrep_strobe_t   strb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [PIX_W-1:0] inPixel,
  output logic [PIX_W-1:0] outPixel,
  output logic             outValid,
  output logic [1:0]       outSegIdx,
  output logic             outLast
);

  logic [PIX_W-1:0] lineMem [MAX_W];

  always_ff @(posedge clk) begin
    if (strb.wrEn) lineMem[wrAddr] <= inPixel;
  end

  // filler beats leave outPixel untouched, so they repeat the last real pixel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPixel  <= '0;
      outValid  <= 1'b0;
      outSegIdx <= '0;
      outLast   <= 1'b0;
    end else begin
      outValid <= strb.emitPix || strb.emitPad;
      outLast  <= strb.last;
      if (strb.emitPix || strb.emitPad) outSegIdx <= strb.seg;
      if (strb.emitPix) outPixel <= lineMem[rdAddr];
    end
  end

  // R1: the line store is never written while the line is played back
  assert_no_write_in_emit_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> !(strb.emitPix || strb.emitPad));

endmodule

// File: rtl/pix_repeat_segmenter.sv
module pix_repeat_segmenter
  import pixrep_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int MAX_W = 64,
  parameter int PAD_W = 4,
  localparam int AW   = $clog2(MAX_W),
  localparam int WW   = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] inPixel,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WW-1:0]    cfgWidth,
  input  logic [1:0]       cfgSegMode,
  input  logic [3:0]       cfgOverlap,
  input  logic [3:0]       cfgRepeat,
  input  logic [PAD_W-1:0] cfgPad,
  output logic [PIX_W-1:0] outPixel,
  output logic             outValid,
  output logic [1:0]       outSegIdx,
  output logic             outLast,
  output logic             cfgErr
);

  pixrep_strobe_t strb;
  logic [AW-1:0]  wrAddr;
  logic [AW-1:0]  rdAddr;

  pixrep_ctrl #(
    .MAX_W(MAX_W), .AW(AW), .WW(WW), .OVL_W(4), .REP_W(4), .PAD_W(PAD_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .cfgWidth(cfgWidth), .cfgSegMode(cfgSegMode), .cfgOverlap(cfgOverlap),
    .cfgRepeat(cfgRepeat), .cfgPad(cfgPad), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .cfgErr(cfgErr)
  );

  pixrep_datapath #(
    .PIX_W(PIX_W), .MAX_W(MAX_W), .AW(AW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inPixel(inPixel), .outPixel(outPixel), .outValid(outValid),
    .outSegIdx(outSegIdx), .outLast(outLast)
  );

  // R1: only the final beat of a line may overlap with collection
  assert_ready_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |-> !inReady);

  // R6: the segment index advances only right after a flagged last beat
  assert_seg_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && (outSegIdx != $past(outSegIdx))) |-> $past(outLast));

  // R7: a rejected configuration plays back as segment 0 only
  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && outValid) |-> (outSegIdx == 2'd0));

endmodule

// File: tb/pix_repeat_segmenter_tb_top.sv
module pix_repeat_segmenter_tb_top;

  localparam int PIX_W = 24;
  localparam int MAX_W = 64;
  localparam int PAD_W = 4;
  localparam int WW    = 7;
  localparam int NBUF  = 8192;

  typedef struct packed {
    logic [6:0] w;
    logic [1:0] mode;
    logic [3:0] ovl;
    logic [3:0] rep;
    logic [3:0] pad;
    logic       err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{7'd8,  2'd0, 4'd0, 4'd0,  4'd0, 1'b0},
    '{7'd8,  2'd0, 4'd0, 4'd2,  4'd0, 1'b0},
    '{7'd16, 2'd1, 4'd2, 4'd0,  4'd0, 1'b0},
    '{7'd16, 2'd2, 4'd3, 4'd1,  4'd2, 1'b0},
    '{7'd12, 2'd2, 4'd1, 4'd0,  4'd1, 1'b0},
    '{7'd10, 2'd2, 4'd0, 4'd0,  4'd0, 1'b1},
    '{7'd9,  2'd1, 4'd0, 4'd1,  4'd0, 1'b1},
    '{7'd8,  2'd3, 4'd0, 4'd0,  4'd0, 1'b1},
    '{7'd8,  2'd2, 4'd8, 4'd0,  4'd0, 1'b0},
    '{7'd64, 2'd2, 4'd8, 4'd15, 4'd3, 1'b0},
    '{7'd1,  2'd0, 4'd0, 4'd15, 4'd0, 1'b0},
    '{7'd4,  2'd1, 4'd1, 4'd0,  4'd5, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [PIX_W-1:0] inPixel = '0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [WW-1:0]    cfgWidth = '0;
  logic [1:0]       cfgSegMode = '0;
  logic [3:0]       cfgOverlap = '0;
  logic [3:0]       cfgRepeat = '0;
  logic [PAD_W-1:0] cfgPad = '0;
  logic [PIX_W-1:0] outPixel;
  logic             outValid;
  logic [1:0]       outSegIdx;
  logic             outLast;
  logic             cfgErr;

  int errors = 0;
  int checks = 0;

  logic [PIX_W-1:0] expPix  [NBUF];
  logic [1:0]       expSeg  [NBUF];
  logic             expLast [NBUF];
  int               expN;

  logic [PIX_W-1:0] gotPix  [NBUF];
  logic [1:0]       gotSeg  [NBUF];
  logic             gotLast [NBUF];
  logic             gotErr  [NBUF];
  int               gotN = 0;
  int               readyViol = 0;

  always #5 clk = ~clk;

  pix_repeat_segmenter #(.PIX_W(PIX_W), .MAX_W(MAX_W), .PAD_W(PAD_W)) dut_i (
    .clk(clk), .rstN(rstN), .inPixel(inPixel), .inValid(inValid), .inReady(inReady),
    .cfgWidth(cfgWidth), .cfgSegMode(cfgSegMode), .cfgOverlap(cfgOverlap),
    .cfgRepeat(cfgRepeat), .cfgPad(cfgPad), .outPixel(outPixel), .outValid(outValid),
    .outSegIdx(outSegIdx), .outLast(outLast), .cfgErr(cfgErr)
  );

  // output collector, samples away from the active edge
  always @(negedge clk) begin
    if (rstN && outValid && gotN < NBUF) begin
      gotPix[gotN]  <= outPixel;
      gotSeg[gotN]  <= outSegIdx;
      gotLast[gotN] <= outLast;
      gotErr[gotN]  <= cfgErr;
      gotN          <= gotN + 1;
      if (!outLast && inReady) readyViol <= readyViol + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  function automatic logic [PIX_W-1:0] pv(input int line, input int i);
    return PIX_W'(line * 4096 + i + 24'h300000);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic buildExp(input vec_t t, input int line);
    int ns, sw, st, en, k;
    logic e;
    e  = (t.mode == 2'd3) || (t.mode == 2'd1 && t.w[0]) || (t.mode == 2'd2 && t.w[1:0] != 2'd0);
    ns = e ? 1 : (t.mode == 2'd0 ? 1 : (t.mode == 2'd1 ? 2 : 4));
    sw = int'(t.w) / ns;
    k  = 0;
    for (int s = 0; s < ns; s++) begin
      st = (s == 0) ? 0 : s * sw - int'(t.ovl);
      if (st < 0) st = 0;
      en = (s + 1) * sw - 1;
      for (int i = st; i <= en; i++) begin
        for (int r = 0; r <= int'(t.rep); r++) begin
          expPix[k]  = pv(line, i);
          expSeg[k]  = 2'(s);
          expLast[k] = (i == en) && (r == int'(t.rep)) && (t.pad == 4'd0);
          k++;
        end
      end
      for (int p = 1; p <= int'(t.pad); p++) begin
        expPix[k]  = pv(line, en);
        expSeg[k]  = 2'(s);
        expLast[k] = (p == int'(t.pad));
        k++;
      end
    end
    expN = k;
  endtask

  task automatic runLine(input vec_t t, input int line, input int chgAt);
    int start, rv0, i, g, pixBad, segBad, lastBad, lastCnt, segCnt;
    buildExp(t, line);
    @(negedge clk);
    start = gotN;
    rv0 = readyViol;
    cfgWidth = t.w; cfgSegMode = t.mode; cfgOverlap = t.ovl;
    cfgRepeat = t.rep; cfgPad = t.pad;
    i = 0; g = 0;
    while (i < int'(t.w) && g < 5000) begin
      @(negedge clk);
      g++;
      if (i == chgAt && chgAt > 0) begin
        // R8: late configuration change, must not affect this line
        cfgWidth = 7'd5; cfgSegMode = 2'd3; cfgRepeat = 4'd7; cfgPad = 4'd0; cfgOverlap = 4'd0;
      end
      inPixel = pv(line, i);
      inValid = 1'b1;
      if (inReady) i++;
    end
    @(negedge clk);
    inValid = 1'b0;
    check(!inReady, "R1 ready low after line", 32'(inReady), 32'd0);
    g = 0;
    while ((gotN - start) < expN && g < 30000) begin
      @(negedge clk);
      g++;
    end
    repeat (4) @(negedge clk);
    check((gotN - start) == expN, "R2 R5 beat count", 32'(gotN - start), 32'(expN));
    pixBad = -1; segBad = -1; lastBad = -1;
    for (int k = 0; k < expN && (start + k) < gotN; k++) begin
      if (pixBad < 0 && gotPix[start + k] != expPix[k]) pixBad = k;
      if (segBad < 0 && gotSeg[start + k] != expSeg[k]) segBad = k;
      if (lastBad < 0 && gotLast[start + k] != expLast[k]) lastBad = k;
    end
    check(pixBad < 0, "R2 R4 R5 pixel sequence",
          pixBad < 0 ? 32'd0 : 32'(gotPix[start + pixBad]), pixBad < 0 ? 32'd0 : 32'(expPix[pixBad]));
    check(segBad < 0, "R3 segment index",
          segBad < 0 ? 32'd0 : 32'(gotSeg[start + segBad]), segBad < 0 ? 32'd0 : 32'(expSeg[segBad]));
    lastCnt = 0; segCnt = 0;
    for (int k = 0; k < expN; k++) if (expLast[k]) segCnt++;
    for (int k = start; k < gotN; k++) if (gotLast[k]) lastCnt++;
    check(lastBad < 0 && lastCnt == segCnt, "R6 last flag position",
          32'(lastCnt), 32'(segCnt));
    check(gotN > start && gotErr[start] == t.err, "R7 error flag",
          gotN > start ? 32'(gotErr[start]) : 32'hx, 32'(t.err));
    check(readyViol == rv0 && inReady, "R1 ready during playback",
          32'(readyViol - rv0), 32'd0);
    if (chgAt > 0)
      check(pixBad < 0 && segBad < 0 && (gotN - start) == expN,
            "R8 late config ignored", 32'(gotN - start), 32'(expN));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid, "R9 reset outValid", 32'(outValid), 32'd0);
    check(inReady, "R9 reset inReady", 32'(inReady), 32'd1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!outValid && inReady && !cfgErr, "R9 idle after reset",
          {29'd0, outValid, inReady, cfgErr}, 32'd2);
    for (int v = 0; v < NV; v++) runLine(VECS[v], v + 1, -1);
    runLine('{7'd16, 2'd1, 4'd2, 4'd1, 4'd1, 1'b0}, 40, 3);
    runLine('{7'd8, 2'd2, 4'd1, 4'd0, 4'd0, 1'b0}, 41, 5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule